// File: doc/BRIEF.md
# Three-Tap Systolic FIR Filter with Stationary Coefficients

This block filters a stream of signed 8-bit samples with a short finite impulse response, y(n) = w0·x(n) + w1·x(n-1) + w2·x(n-2). It is built as a linear row of identical multiply-add elements, one per tap. Each element keeps its own coefficient for as long as no new value is written to it. A synthesis-time parameter chooses how the samples and the partial sums reach the elements.

With `MAPPING = MAP_BCAST`, every element sees the current sample in the same cycle, and the partial sums move one element to the left through a register at each step. With `MAPPING = MAP_SHIFT`, the samples move to the right through one register per element, and the products are added up from right to left by a purely combinational chain. Each element does one multiply-add per accepted sample in both mappings. The two mappings give the same result sequence and differ only in latency.

Coefficients are written one at a time through an index and data port. A write resets the sample history, so the filter starts again as it does after reset. The sample input and the result output each carry a valid flag. The history moves forward only on accepted samples.

Top module: `fir3_systolic`

## Requirements
- R1: For each accepted sample the result is w0·x(n) + w1·x(n-1) + w2·x(n-2), computed in two's complement from 8-bit signed samples and weights. The result is given as an 18-bit signed value, and every combination of inputs, including -128·-128 on all three taps (49152), is exact.
- R2: With `MAPPING = MAP_BCAST`, `out_valid` is high for one cycle exactly one clock after each accepted sample, and `out_result` holds that sample's result in the same cycle.
- R3: With `MAPPING = MAP_SHIFT`, `out_valid` is high for one cycle exactly two clocks after each accepted sample, and `out_result` holds that sample's result in the same cycle.
- R4: `out_valid` stays low in any cycle that does not correspond to an accepted sample. Cycles with `in_valid` low do not move the history, so x(n-1) and x(n-2) are always the previous accepted samples.
- R5: While reset is asserted (`rst_n` low) `out_valid` is low. After reset all weights and all stored samples are zero, so results are zero until weights are written.
- R6: A cycle with `wt_we` high and `wt_idx` = k (0, 1 or 2) sets weight wk to `wt_data`, and the next accepted sample uses it. A write with `wt_idx` = 3 changes no weight.
- R7: Any weight write, including one to index 3, clears the sample history. The first two results after the write treat the earlier samples as zero.
- R8: A sample presented with `in_valid` high in the same cycle as `wt_we` is not accepted. It produces no result and does not enter the history.
- R9: A weight write in the cycle right after an accepted sample does not change that sample's result, which uses the old weights and the old history in both mappings.
- R10: For any input sequence, the `MAP_SHIFT` variant produces the same result sequence as the `MAP_BCAST` variant, delayed by one clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| wt_we | input | 1 | Weight write strobe |
| wt_idx | input | 2 | Tap index of the weight being written |
| wt_data | input | 8 | Signed weight value |
| in_valid | input | 1 | Sample is present on `in_sample` |
| in_sample | input | 8 | Signed input sample |
| out_valid | output | 1 | `out_result` holds a new result |
| out_result | output | 18 | Signed filter result |

## Verification
The hardest case to reach is a weight write in the cycle right after a sample. In the moving-input variant that sample is still between the input register and the output register, so its sum must use the old weights and the uncleared history while both change at the same edge. Stalls between samples are a second such case, because the history must hold still through them. The bench drives long pseudo-random streams in which writes, stalls and writes that collide with a sample are mixed in at random cycles. It runs both variants side by side against one behavioural model and compares them cycle by cycle.

// File: rtl/fir_pkg.sv
package fir_pkg;
    typedef enum logic {
        MAP_BCAST = 1'b0,
        MAP_SHIFT = 1'b1
    } map_e;
endpackage

// File: rtl/fir_pe.sv
module fir_pe #(
    parameter int DATA_W = 8,
    parameter int ACC_W  = 18
) (
    input  logic signed [DATA_W-1:0] wt,
    input  logic signed [DATA_W-1:0] smp,
    input  logic signed [ACC_W-1:0]  part_in,
    output logic signed [ACC_W-1:0]  part_out
);
    localparam int PROD_W = 2 * DATA_W;

    logic signed [PROD_W-1:0] prod;

    always_comb begin
        prod     = wt * smp;
        part_out = part_in + ACC_W'(prod);
    end
endmodule

// File: rtl/fir_wt_bank.sv
module fir_wt_bank #(
    parameter int TAPS   = 3,
    parameter int DATA_W = 8,
    parameter int IDX_W  = 2
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         we,
    input  logic [IDX_W-1:0]             idx,
    input  logic [DATA_W-1:0]            data,
    output logic [TAPS-1:0][DATA_W-1:0]  wts
);
    localparam logic [IDX_W:0] NTAPS = (IDX_W + 1)'(TAPS);

    typedef struct packed {
        logic [TAPS-1:0][DATA_W-1:0] w;
    } bank_s;

    bank_s st_d, st_q;
    logic  idx_ok;

    always_comb begin
        idx_ok = ({1'b0, idx} < NTAPS);
        st_d   = st_q;
        if (we && idx_ok) begin
            st_d.w[idx] = data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign wts = st_q.w;

    AST_WT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> $stable(wts)); // R6
    AST_WT_BAD_IDX: assert property (@(posedge clk) disable iff (!rst_n)
        (we && !idx_ok) |=> $stable(wts)); // R6
    AST_WT_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (we && idx_ok) |=> (wts[$past(idx)] == $past(data))); // R6
endmodule

// File: rtl/fir_bcast_array.sv
module fir_bcast_array #(
    parameter int TAPS   = 3,
    parameter int DATA_W = 8,
    parameter int ACC_W  = 18
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         clr,
    input  logic                         acc,
    input  logic [DATA_W-1:0]            smp,
    input  logic [TAPS-1:0][DATA_W-1:0]  wts,
    output logic                         res_vld,
    output logic [ACC_W-1:0]             res
);
    typedef struct packed {
        logic [TAPS-2:0][ACC_W-1:0] part;
        logic                       vld;
        logic [ACC_W-1:0]           y;
    } bc_s;

    bc_s st_d, st_q;

    logic signed [ACC_W-1:0] pin  [TAPS];
    logic signed [ACC_W-1:0] pout [TAPS];

    for (genvar k = 0; k < TAPS; k++) begin : g_pe
        if (k == TAPS - 1) begin : g_edge
            assign pin[k] = '0;
        end else begin : g_inner
            assign pin[k] = $signed(st_q.part[k]);
        end
        fir_pe #(.DATA_W(DATA_W), .ACC_W(ACC_W)) u_pe (
            .wt       ($signed(wts[k])),
            .smp      ($signed(smp)),
            .part_in  (pin[k]),
            .part_out (pout[k])
        );
    end

    always_comb begin
        st_d     = st_q;
        st_d.vld = acc;
        if (clr) begin
            st_d.part = '0;
        end else if (acc) begin
            for (int j = 0; j < TAPS - 1; j++) begin
                st_d.part[j] = pout[j+1];
            end
            st_d.y = pout[0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign res_vld = st_q.vld;
    assign res     = st_q.y;

    AST_PART_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!acc && !clr) |=> $stable(st_q.part)); // R4
    AST_PART_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (st_q.part == '0)); // R7
endmodule

// File: rtl/fir_shift_array.sv
module fir_shift_array #(
    parameter int TAPS   = 3,
    parameter int DATA_W = 8,
    parameter int ACC_W  = 18
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         clr,
    input  logic                         acc,
    input  logic [DATA_W-1:0]            smp,
    input  logic [TAPS-1:0][DATA_W-1:0]  wts,
    output logic                         res_vld,
    output logic [ACC_W-1:0]             res
);
    typedef struct packed {
        logic [TAPS-1:0][DATA_W-1:0] xs;
        logic                        stg_vld;
        logic                        vld;
        logic [ACC_W-1:0]            y;
    } sh_s;

    sh_s st_d, st_q;

    logic signed [ACC_W-1:0] pin  [TAPS];
    logic signed [ACC_W-1:0] pout [TAPS];

    for (genvar k = 0; k < TAPS; k++) begin : g_pe
        if (k == TAPS - 1) begin : g_edge
            assign pin[k] = '0;
        end else begin : g_inner
            assign pin[k] = pout[k+1];
        end
        fir_pe #(.DATA_W(DATA_W), .ACC_W(ACC_W)) u_pe (
            .wt       ($signed(wts[k])),
            .smp      ($signed(st_q.xs[k])),
            .part_in  (pin[k]),
            .part_out (pout[k])
        );
    end

    always_comb begin
        st_d         = st_q;
        st_d.stg_vld = acc;
        st_d.vld     = st_q.stg_vld;
        if (st_q.stg_vld) begin
            st_d.y = pout[0];
        end
        if (clr) begin
            st_d.xs = '0;
        end else if (acc) begin
            st_d.xs[0] = smp;
            for (int j = 1; j < TAPS; j++) begin
                st_d.xs[j] = st_q.xs[j-1];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign res_vld = st_q.vld;
    assign res     = st_q.y;

    AST_SHIFT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!acc && !clr) |=> $stable(st_q.xs)); // R4
    AST_SHIFT_MOVE: assert property (@(posedge clk) disable iff (!rst_n)
        acc |=> (st_q.xs[1] == $past(st_q.xs[0]))); // R4
endmodule

// File: rtl/fir3_systolic.sv
module fir3_systolic #(
    parameter fir_pkg::map_e MAPPING = fir_pkg::MAP_BCAST,
    parameter int TAPS   = 3,
    parameter int DATA_W = 8,
    parameter int IDX_W  = $clog2(TAPS),
    parameter int ACC_W  = 2 * DATA_W + $clog2(TAPS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wt_we,
    input  logic [IDX_W-1:0]  wt_idx,
    input  logic [DATA_W-1:0] wt_data,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_sample,
    output logic              out_valid,
    output logic [ACC_W-1:0]  out_result
);
    localparam int BOUND = TAPS * (2 ** (2 * DATA_W - 2));

    logic                        acc;
    logic [TAPS-1:0][DATA_W-1:0] wts;

    assign acc = in_valid && !wt_we;

    fir_wt_bank #(.TAPS(TAPS), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_bank (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (wt_we),
        .idx   (wt_idx),
        .data  (wt_data),
        .wts   (wts)
    );

    if (MAPPING == fir_pkg::MAP_BCAST) begin : g_bcast
        fir_bcast_array #(.TAPS(TAPS), .DATA_W(DATA_W), .ACC_W(ACC_W)) u_arr (
            .clk     (clk),
            .rst_n   (rst_n),
            .clr     (wt_we),
            .acc     (acc),
            .smp     (in_sample),
            .wts     (wts),
            .res_vld (out_valid),
            .res     (out_result)
        );
        AST_LATENCY_ONE: assert property (@(posedge clk) disable iff (!rst_n)
            out_valid == $past(in_valid && !wt_we)); // R2
        AST_BLOCKED_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
            wt_we |=> !out_valid); // R8
    end else begin : g_shift
        fir_shift_array #(.TAPS(TAPS), .DATA_W(DATA_W), .ACC_W(ACC_W)) u_arr (
            .clk     (clk),
            .rst_n   (rst_n),
            .clr     (wt_we),
            .acc     (acc),
            .smp     (in_sample),
            .wts     (wts),
            .res_vld (out_valid),
            .res     (out_result)
        );
        AST_LATENCY_TWO: assert property (@(posedge clk) disable iff (!rst_n)
            out_valid == $past(in_valid && !wt_we, 2)); // R3
        AST_BLOCKED_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
            wt_we |=> ##1 !out_valid); // R8
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ($signed(out_result) <= BOUND && $signed(out_result) >= -BOUND)); // R1
endmodule

// File: tb/tb_fir3_systolic.sv
module tb_fir3_systolic;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wt_we = 1'b0;
    logic [1:0]  wt_idx = '0;
    logic [7:0]  wt_data = '0;
    logic        in_valid = 1'b0;
    logic [7:0]  in_sample = '0;
    logic        ov_b, ov_s;
    logic [17:0] res_b, res_s;

    int checks = 0;
    int errors = 0;
    int w [3];
    int h1, h2;
    bit pv;
    int py;
    bit prev_bv;
    int prev_by;

    always #4 clk = ~clk;

    fir3_systolic #(.MAPPING(fir_pkg::MAP_BCAST)) dut (
        .clk(clk), .rst_n(rst_n), .wt_we(wt_we), .wt_idx(wt_idx), .wt_data(wt_data),
        .in_valid(in_valid), .in_sample(in_sample), .out_valid(ov_b), .out_result(res_b));

    fir3_systolic #(.MAPPING(fir_pkg::MAP_SHIFT)) dut_mi (
        .clk(clk), .rst_n(rst_n), .wt_we(wt_we), .wt_idx(wt_idx), .wt_data(wt_data),
        .in_valid(in_valid), .in_sample(in_sample), .out_valid(ov_s), .out_result(res_s));

    task automatic check_out(input string tag, input string who, input logic av, input int ay,
                             input bit ev, input int ey);
        checks++;
        if (av !== ev || (ev && ay != ey)) begin
            errors++;
            $display("FAIL %s %s: valid=%0b result=%0d expected valid=%0b result=%0d",
                     tag, who, av, ay, ev, ey);
        end
    endtask

    task automatic step(input bit we, input int idx, input int data, input bit iv, input int x,
                        input string tag);
        bit ev;
        int ey;
        wt_we     = we;
        wt_idx    = idx[1:0];
        wt_data   = data[7:0];
        in_valid  = iv;
        in_sample = x[7:0];
        ev = iv && !we;
        ey = 0;
        if (we) begin
            if (idx < 3) w[idx] = data;
            h1 = 0;
            h2 = 0;
        end
        if (ev) begin
            ey = w[0] * x + w[1] * h1 + w[2] * h2;
            h2 = h1;
            h1 = x;
        end
        @(posedge clk);
        #1;
        check_out(tag, "bcast", ov_b, $signed(res_b), ev, ey);
        check_out(tag, "shift", ov_s, $signed(res_s), pv, py);
        check_out("R10", "shift-vs-bcast", ov_s, $signed(res_s), prev_bv, prev_by);
        pv = ev;
        py = ey;
        prev_bv = ov_b;
        prev_by = $signed(res_b);
    endtask

    task automatic sample(input int x, input string tag);
        step(1'b0, 0, 0, 1'b1, x, tag);
    endtask

    task automatic idle(input string tag);
        step(1'b0, 0, 0, 1'b0, 0, tag);
    endtask

    task automatic load(input int idx, input int data, input string tag);
        step(1'b1, idx, data, 1'b0, 0, tag);
    endtask

    function automatic int rnd8();
        return int'($urandom_range(255)) - 128;
    endfunction

    initial begin
        repeat (50000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not complete, expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < 3; i++) w[i] = 0;
        h1 = 0; h2 = 0; pv = 0; py = 0; prev_bv = 0; prev_by = 0;
        repeat (3) @(posedge clk);
        #1;
        // R5: quiet during reset
        check_out("R5", "bcast", ov_b, 0, 1'b0, 0);
        check_out("R5", "shift", ov_s, 0, 1'b0, 0);
        rst_n = 1'b1;

        // R5: zero weights after reset
        sample(100, "R5"); sample(-50, "R5"); sample(7, "R5"); idle("R5"); idle("R5");

        // R6, R7, R1, R2, R3: load weights, fresh history
        load(0, 3, "R6"); load(1, -2, "R6"); load(2, 5, "R6");
        sample(10, "R7"); sample(20, "R7"); sample(30, "R1"); sample(-7, "R2");
        idle("R3"); idle("R3");

        // R4: stalls keep history
        sample(11, "R4"); idle("R4"); idle("R4"); sample(-3, "R4"); idle("R4");
        sample(9, "R4"); idle("R4"); idle("R4"); idle("R4");

        // R1: extreme values
        load(0, -128, "R1"); load(1, -128, "R1"); load(2, -128, "R1");
        for (int i = 0; i < 4; i++) sample(-128, "R1");
        load(0, 127, "R1"); load(1, 127, "R1"); load(2, 127, "R1");
        for (int i = 0; i < 4; i++) sample(-128, "R1");
        idle("R1"); idle("R1");

        // R6, R7: index 3 changes no weight but clears history
        sample(40, "R7"); sample(41, "R7");
        load(3, 99, "R6");
        sample(5, "R6"); sample(6, "R6"); sample(7, "R6"); idle("R6"); idle("R6");

        // R8: sample during write is dropped
        sample(12, "R8");
        step(1'b1, 1, 4, 1'b1, 77, "R8");
        sample(13, "R8"); sample(14, "R8"); idle("R8"); idle("R8");

        // R9: write right after a sample
        sample(21, "R9");
        load(0, -9, "R9");
        sample(22, "R9");
        sample(23, "R9");
        load(2, 2, "R9");
        idle("R9"); idle("R9");

        // R10: pseudo-random mix
        for (int i = 0; i < 600; i++) begin
            int r;
            r = int'($urandom_range(99));
            if (r < 6)       step(1'b1, int'($urandom_range(3)), rnd8(), 1'b0, 0, "R10");
            else if (r < 9)  step(1'b1, int'($urandom_range(3)), rnd8(), 1'b1, rnd8(), "R10");
            else if (r < 75) sample(rnd8(), "R10");
            else             idle("R10");
        end
        idle("R10"); idle("R10");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule